// File: doc/BRIEF.md
# Single-Precision Result Packer

This block converts an unpacked floating-point value, as produced inside an arithmetic datapath, into a 32-bit single-precision word. The value arrives as a class code, a sign, an unbiased signed exponent, a mantissa and a sticky bit. The mantissa carries a leading integer bit, the fraction bits, a guard bit and a round bit. The block rounds the value in one of four directions and picks the packed encoding. It covers zero, infinity, NaN, normal results, results that fall into the subnormal range and results that exceed the largest finite value. It also raises the overflow, underflow and inexact flags that go with the result.

The packed word and its flags are registered and appear one clock after the input is presented with its valid bit. A new value can be accepted on every clock. Normal and subnormal results share one rounding unit. A subnormal result is first shifted right by its exponent deficit, and the bits shifted out are folded into the sticky bit. On overflow, the rounding direction and the sign decide whether the result saturates to infinity or to the largest finite magnitude.

Top module: `sp_result_pack`

## Requirements
- R1: A value presented with `in_valid` high appears on `out_word` and the flag outputs one clock later, with `out_valid` high in that cycle only. The word is laid out as sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. Values can be presented back to back.
- R2: Class code 0 (zero) packs to the sign bit alone, with all three flags low.
- R3: Class code 2 (infinity) packs to the sign, exponent field 0xFF and a zero fraction, with all three flags low.
- R4: Class code 3 (NaN) packs to the sign and exponent field 0xFF. The fraction is the 22 mantissa bits `in_mant[23:2]` below a fraction MSB that is forced to 1. All three flags are low.
- R5: For class code 1 (number), the biased exponent is `in_exp + 127`. `in_mant[25]` is the leading one, `in_mant[24:2]` is the fraction, `in_mant[1]` is the guard bit and `in_mant[0]` is the round bit. Inexact is raised whenever the guard bit, the round bit or the sticky bit that reaches rounding is nonzero.
- R6: Rounding mode 0 rounds to nearest with ties to even. Mode 1 truncates. Mode 2 increments an inexact positive value. Mode 3 increments an inexact negative value.
- R7: A normal result whose rounding carries the significand to 2.0 gets its exponent incremented by one and a zero fraction.
- R8: A number whose biased exponent is 0 or less is shifted right by one plus its deficit before rounding. Every bit shifted out joins the sticky bit, and the result is packed with exponent field 0.
- R9: When a subnormal result rounds up to a fraction of 1<<23, the word becomes the smallest normal (exponent field 1, fraction 0). Underflow stays low in this case and inexact is raised.
- R10: A result that stays subnormal raises underflow when it is inexact or when `ufl_trap_en` is high. It raises no underflow when it is exact and the enable is low.
- R11: A normal result whose biased exponent after rounding is 255 or more always raises inexact. It packs to infinity and raises overflow in mode 0, in mode 2 when positive, and in mode 3 when negative. Otherwise it packs to exponent 0xFE with all fraction bits set and overflow low.
- R12: While `rst_n` is low, `out_valid`, `out_word` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value is present |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 26 | Leading bit, 23 fraction bits, guard, round |
| in_sticky | input | 1 | OR of all bits below the round bit |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| ufl_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Packed result is present |
| out_word | output | 32 | Packed single-precision word |
| out_ovf | output | 1 | Overflow to infinity |
| out_ufl | output | 1 | Underflow |
| out_inx | output | 1 | Inexact |

## Verification
Every result, the word and all three flags together, is due exactly one clock after its input is accepted. The bench applies each input on a falling edge. On the next falling edge it compares the outputs against the model's prediction for that input, and only then applies the following input. Between vectors it compares `out_valid` against the expected value every cycle, including idle cycles. This shows that a result never arrives early, late or twice. Directed vectors aim at ties, carry to 2.0, the exact boundary into the smallest normal, very deep subnormals and overflow in every mode and sign. A random sweep across the subnormal-to-overflow exponent range then covers the cases in between.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NUM  = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } val_class_e;

   typedef enum logic [1:0] {
      RND_NEAR = 2'd0,
      RND_ZERO = 2'd1,
      RND_UP   = 2'd2,
      RND_DOWN = 2'd3
   } rnd_mode_e;

   typedef struct packed {
      logic ovf;
      logic ufl;
      logic inx;
   } pack_flags_t;

endpackage

// File: rtl/sp_align.sv
// Right shift of the mantissa for the subnormal path; lost bits fold into sticky.
module sp_align #(
   parameter int MAN_W = 26,
   parameter int SH_W  = 5
) (
   input  logic [MAN_W-1:0] mant_i,
   input  logic             sticky_i,
   input  logic [SH_W-1:0]  shamt_i,
   output logic [MAN_W-1:0] mant_o,
   output logic             sticky_o
);

   generate
      if ((1 << SH_W) <= MAN_W) begin : g_chk_sh
         $error("sp_align: SH_W too narrow to flush the mantissa");
      end
   endgenerate

   logic [MAN_W-1:0] lost_mask;

   always_comb begin
      lost_mask = ~({MAN_W{1'b1}} << shamt_i);
      mant_o    = mant_i >> shamt_i;
      sticky_o  = sticky_i | (|(mant_i & lost_mask));
   end

endmodule

// File: rtl/sp_round.sv
// Directed rounding of a kept significand using guard, round and sticky.
module sp_round
   import sp_pack_pkg::*;
#(
   parameter int FRAC_W   = 23,
   parameter bit TIE_EVEN = 1'b1
) (
   input  logic [FRAC_W+2:0] mant_i,
   input  logic              sticky_i,
   input  logic              sign_i,
   input  rnd_mode_e         mode_i,
   output logic [FRAC_W+1:0] sum_o,
   output logic              inexact_o,
   output logic              bump_o
);

   localparam int KEEP_W = FRAC_W + 1;

   logic [KEEP_W-1:0] kept;
   logic              grd;
   logic              rnd;
   logic              near_bump;

   assign kept      = mant_i[FRAC_W+2:2];
   assign grd       = mant_i[1];
   assign rnd       = mant_i[0];
   assign inexact_o = grd | rnd | sticky_i;

   generate
      if (TIE_EVEN) begin : g_tie_even
         assign near_bump = grd & (rnd | sticky_i | kept[0]);
      end else begin : g_tie_away
         assign near_bump = grd;
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         RND_NEAR: bump_o = near_bump;
         RND_ZERO: bump_o = 1'b0;
         RND_UP:   bump_o = inexact_o & ~sign_i;
         RND_DOWN: bump_o = inexact_o & sign_i;
         default:  bump_o = 1'b0;
      endcase
      sum_o = {1'b0, kept} + {{KEEP_W{1'b0}}, bump_o};
   end

endmodule

// File: rtl/sp_ovf_sel.sv
// Decides whether an overflowing result saturates to infinity.
module sp_ovf_sel
   import sp_pack_pkg::*;
(
   input  logic      sign_i,
   input  rnd_mode_e mode_i,
   output logic      to_inf_o
);

   always_comb begin
      unique case (mode_i)
         RND_NEAR: to_inf_o = 1'b1;
         RND_ZERO: to_inf_o = 1'b0;
         RND_UP:   to_inf_o = ~sign_i;
         RND_DOWN: to_inf_o = sign_i;
         default:  to_inf_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/sp_result_pack.sv
module sp_result_pack
   import sp_pack_pkg::*;
#(
   parameter int EXP_W    = 10,
   parameter int FRAC_W   = 23,
   parameter int EW       = 8,
   parameter bit OUT_REG  = 1'b1,
   parameter bit TIE_EVEN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           in_class,
   input  logic                 in_sign,
   input  logic [EXP_W-1:0]     in_exp,
   input  logic [FRAC_W+2:0]    in_mant,
   input  logic                 in_sticky,
   input  logic [1:0]           rnd_mode,
   input  logic                 ufl_trap_en,
   output logic                 out_valid,
   output logic [EW+FRAC_W:0]   out_word,
   output logic                 out_ovf,
   output logic                 out_ufl,
   output logic                 out_inx
);

   localparam int MAN_W  = FRAC_W + 3;
   localparam int WORD_W = 1 + EW + FRAC_W;
   localparam int BIAS   = (1 << (EW - 1)) - 1;
   localparam int EMAX   = (1 << EW) - 1;
   localparam int BE_W   = EXP_W + 2;
   localparam int SH_W   = $clog2(MAN_W + 1);

   localparam logic signed [BE_W-1:0] BIAS_S  = BE_W'(BIAS);
   localparam logic signed [BE_W-1:0] EMAX_S  = BE_W'(EMAX);
   localparam logic signed [BE_W-1:0] MANW_S  = BE_W'(MAN_W);
   localparam logic signed [BE_W-1:0] ONE_S   = BE_W'(1);

   generate
      if (EW < 3) begin : g_chk_ew
         $error("sp_result_pack: EW must be at least 3");
      end
      if (FRAC_W < 2) begin : g_chk_frac
         $error("sp_result_pack: FRAC_W must be at least 2");
      end
      if (EXP_W < EW + 1) begin : g_chk_exp
         $error("sp_result_pack: EXP_W must cover the packed exponent range");
      end
   endgenerate

   val_class_e cls;
   rnd_mode_e  mode;

   assign cls  = val_class_e'(in_class);
   assign mode = rnd_mode_e'(rnd_mode);

   // ---------------- exponent and alignment ----------------
   logic signed [BE_W-1:0] be;
   logic signed [BE_W-1:0] deficit;
   logic                   is_sub;
   logic [SH_W-1:0]        shamt;

   always_comb begin
      be      = {{2{in_exp[EXP_W-1]}}, in_exp} + BIAS_S;
      is_sub  = (be <= 0);
      deficit = ONE_S - be;
      if (!is_sub)
         shamt = '0;
      else if (deficit > MANW_S)
         shamt = SH_W'(MAN_W);
      else
         shamt = deficit[SH_W-1:0];
   end

   logic [MAN_W-1:0] al_mant;
   logic             al_sticky;

   sp_align #(
      .MAN_W (MAN_W),
      .SH_W  (SH_W)
   ) u_align (
      .mant_i   (in_mant),
      .sticky_i (in_sticky),
      .shamt_i  (shamt),
      .mant_o   (al_mant),
      .sticky_o (al_sticky)
   );

   // ---------------- rounding ----------------
   logic [FRAC_W+1:0] rsum;
   logic              rinexact;
   logic              rbump;

   sp_round #(
      .FRAC_W   (FRAC_W),
      .TIE_EVEN (TIE_EVEN)
   ) u_round (
      .mant_i    (al_mant),
      .sticky_i  (al_sticky),
      .sign_i    (in_sign),
      .mode_i    (mode),
      .sum_o     (rsum),
      .inexact_o (rinexact),
      .bump_o    (rbump)
   );

   logic to_inf;

   sp_ovf_sel u_ovf_sel (
      .sign_i   (in_sign),
      .mode_i   (mode),
      .to_inf_o (to_inf)
   );

   // ---------------- result selection ----------------
   logic signed [BE_W-1:0] be_post;
   logic                   ovf_case;
   logic [WORD_W-1:0]      res_word;
   pack_flags_t            res_flags;

   always_comb begin
      be_post   = be + {{(BE_W-1){1'b0}}, rsum[FRAC_W+1]};
      ovf_case  = !is_sub && (be_post >= EMAX_S);
      res_word  = {in_sign, {(WORD_W-1){1'b0}}};
      res_flags = '0;
      unique case (cls)
         CLS_ZERO: res_word = {in_sign, {(WORD_W-1){1'b0}}};
         CLS_INF:  res_word = {in_sign, {EW{1'b1}}, {FRAC_W{1'b0}}};
         CLS_NAN:  res_word = {in_sign, {EW{1'b1}}, 1'b1, in_mant[FRAC_W:2]};
         CLS_NUM: begin
            if (is_sub) begin
               res_flags.inx = rinexact;
               if (rsum[FRAC_W]) begin
                  res_word = {in_sign, EW'(1), {FRAC_W{1'b0}}};
               end else begin
                  res_word      = {in_sign, {EW{1'b0}}, rsum[FRAC_W-1:0]};
                  res_flags.ufl = rinexact | ufl_trap_en;
               end
            end else if (ovf_case) begin
               res_flags.inx = 1'b1;
               if (to_inf) begin
                  res_word      = {in_sign, {EW{1'b1}}, {FRAC_W{1'b0}}};
                  res_flags.ovf = 1'b1;
               end else begin
                  res_word = {in_sign, {(EW-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
               end
            end else begin
               res_word      = {in_sign, be_post[EW-1:0], rsum[FRAC_W-1:0]};
               res_flags.inx = rinexact;
            end
         end
         default: res_word = {in_sign, {(WORD_W-1){1'b0}}};
      endcase
   end

   // ---------------- output stage ----------------
   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_word  <= '0;
               out_ovf   <= 1'b0;
               out_ufl   <= 1'b0;
               out_inx   <= 1'b0;
            end else begin
               out_valid <= in_valid;
               out_word  <= in_valid ? res_word : '0;
               out_ovf   <= in_valid & res_flags.ovf;
               out_ufl   <= in_valid & res_flags.ufl;
               out_inx   <= in_valid & res_flags.inx;
            end
         end

         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R1
      end else begin : g_out_comb
         assign out_valid = in_valid;
         assign out_word  = in_valid ? res_word : '0;
         assign out_ovf   = in_valid & res_flags.ovf;
         assign out_ufl   = in_valid & res_flags.ufl;
         assign out_inx   = in_valid & res_flags.inx;
      end
   endgenerate

   // ---------------- assertions ----------------
   AST_ZERO_BARE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_ZERO) |-> (res_word[WORD_W-2:0] == '0 && res_flags == '0)); // R2
   AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cls == CLS_NAN) |-> (&res_word[WORD_W-2 -: EW] && res_word[FRAC_W-1])); // R4
   AST_BUMP_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rbump) |-> rinexact); // R6
   AST_UFL_TINY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && res_flags.ufl) |-> (res_word[WORD_W-2 -: EW] == '0)); // R10
   AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && res_flags.ovf) |-> (&res_word[WORD_W-2 -: EW] && res_word[FRAC_W-1:0] == '0 && res_flags.inx)); // R11
   AST_RZ_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == RND_ZERO) |-> !res_flags.ovf); // R11

endmodule

// File: tb/sp_result_pack_tb.sv
`timescale 1ns/1ps
module sp_result_pack_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_class = 2'd0;
   logic        in_sign = 1'b0;
   logic [9:0]  in_exp = 10'd0;
   logic [25:0] in_mant = 26'd0;
   logic        in_sticky = 1'b0;
   logic [1:0]  rnd_mode = 2'd0;
   logic        ufl_trap_en = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_ovf, out_ufl, out_inx;

   always #4 clk = ~clk;

   sp_result_pack u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
      .rnd_mode(rnd_mode), .ufl_trap_en(ufl_trap_en), .out_valid(out_valid),
      .out_word(out_word), .out_ovf(out_ovf), .out_ufl(out_ufl), .out_inx(out_inx)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   logic  pv = 1'b0;
   logic [31:0] pw = '0;
   logic [2:0]  pf = '0;
   string ptag = "R1";

   localparam logic [25:0] ONE = 26'h2000000;

   // Behavioural reference: returns {ovf, ufl, inx, word}
   function automatic logic [34:0] ref_pack(input logic [1:0] c, input logic s, input int e,
                                            input logic [25:0] m, input logic st,
                                            input logic [1:0] md, input logic ute);
      logic [31:0] w;
      bit ov = 0, uf = 0, ix = 0, stk, up, g, r;
      longint mm, q;
      int be;
      if (c == 2'd0) return {3'b000, s, 31'd0};
      if (c == 2'd2) return {3'b000, s, 8'hFF, 23'd0};
      if (c == 2'd3) return {3'b000, s, 8'hFF, 1'b1, m[23:2]};
      be = e + 127;
      mm = longint'(m);
      stk = st;
      if (be <= 0)
         for (int i = 0; i < 1 - be && i < 40; i++) begin
            stk = stk | mm[0];
            mm = mm >> 1;
         end
      g = mm[1];
      r = mm[0];
      q = mm >> 2;
      ix = g | r | stk;
      case (md)
         2'd0: up = g && (r || stk || q[0]);
         2'd1: up = 0;
         2'd2: up = ix && !s;
         default: up = ix && s;
      endcase
      q = q + longint'(up);
      if (be <= 0) begin
         if (q == (64'd1 << 23)) w = {s, 8'd1, 23'd0};
         else begin
            w = {s, 8'd0, q[22:0]};
            uf = ix || ute;
         end
      end else begin
         if (q == (64'd1 << 24)) be = be + 1;
         if (be >= 255) begin
            ix = 1;
            if (md == 2'd0 || (md == 2'd2 && !s) || (md == 2'd3 && s)) begin
               w = {s, 8'hFF, 23'd0};
               ov = 1;
            end else w = {s, 8'hFE, 23'h7FFFFF};
         end else w = {s, be[7:0], q[22:0]};
      end
      return {ov, uf, ix, w};
   endfunction

   task automatic check_prev();
      n_chk++;
      if (out_valid !== pv) begin
         n_fail++;
         $display("FAIL R1 out_valid actual %b expected %b", out_valid, pv);
      end
      if (pv) begin
         n_chk++;
         if (out_word !== pw) begin
            n_fail++;
            $display("FAIL %s word actual %h expected %h", ptag, out_word, pw);
         end
         n_chk++;
         if ({out_ovf, out_ufl, out_inx} !== pf) begin
            n_fail++;
            $display("FAIL %s flags(ovf,ufl,inx) actual %b expected %b", ptag,
                     {out_ovf, out_ufl, out_inx}, pf);
         end
      end
   endtask

   task automatic drv(input logic v, input logic [1:0] c, input logic s, input int e,
                      input logic [25:0] m, input logic st, input logic [1:0] md,
                      input logic ute, input string tag);
      logic [34:0] x;
      @(negedge clk);
      check_prev();
      in_valid = v; in_class = c; in_sign = s; in_exp = e[9:0]; in_mant = m;
      in_sticky = st; rnd_mode = md; ufl_trap_en = ute;
      x = ref_pack(c, s, e, m, st, md, ute);
      pv = v;
      pw = x[31:0];
      pf = x[34:32];
      ptag = tag;
   endtask

   task automatic idle();
      drv(1'b0, 2'd0, 1'b0, 0, 26'd0, 1'b0, 2'd0, 1'b0, "R1");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      n_chk++;
      if ({out_valid, out_word, out_ovf, out_ufl, out_inx} !== '0) begin
         n_fail++;
         $display("FAIL R12 reset outputs actual %b_%h_%b expected 0_00000000_000",
                  out_valid, out_word, {out_ovf, out_ufl, out_inx});
      end
      rst_n = 1'b1;

      // R2 zero, R3 infinity, R4 NaN
      drv(1, 2'd0, 0, 5, ONE, 1, 2'd0, 1, "R2");
      drv(1, 2'd0, 1, 0, ONE, 0, 2'd2, 0, "R2");
      drv(1, 2'd2, 1, 0, 26'h3FFFFFF, 1, 2'd0, 1, "R3");
      drv(1, 2'd2, 0, 0, 26'd0, 0, 2'd1, 0, "R3");
      drv(1, 2'd3, 0, 0, ONE | 26'h4, 0, 2'd0, 0, "R4");
      drv(1, 2'd3, 1, 0, 26'h3FFFFFF, 0, 2'd0, 0, "R4");
      idle();
      // R5 normal exact values
      drv(1, 2'd1, 0, 0, ONE, 0, 2'd0, 0, "R5");
      drv(1, 2'd1, 0, 3, 26'h3000000, 0, 2'd0, 0, "R5");
      drv(1, 2'd1, 1, -126, ONE, 0, 2'd0, 1, "R5");
      // R6 rounding modes
      drv(1, 2'd1, 0, 0, ONE | 26'h2, 0, 2'd0, 0, "R6");
      drv(1, 2'd1, 0, 0, ONE | 26'h6, 0, 2'd0, 0, "R6");
      drv(1, 2'd1, 0, 0, ONE | 26'h2, 1, 2'd0, 0, "R6");
      drv(1, 2'd1, 0, 0, ONE | 26'h3, 0, 2'd1, 0, "R6");
      drv(1, 2'd1, 0, 0, ONE, 1, 2'd2, 0, "R6");
      drv(1, 2'd1, 1, 0, ONE, 1, 2'd2, 0, "R6");
      drv(1, 2'd1, 1, 0, ONE | 26'h1, 0, 2'd3, 0, "R6");
      drv(1, 2'd1, 0, 0, ONE | 26'h1, 0, 2'd3, 0, "R6");
      // R7 carry to 2.0
      drv(1, 2'd1, 0, 5, 26'h3FFFFFE, 0, 2'd0, 0, "R7");
      drv(1, 2'd1, 1, -3, 26'h3FFFFFC, 1, 2'd3, 0, "R7");
      idle();
      // R8 subnormal alignment
      drv(1, 2'd1, 0, -127, ONE, 0, 2'd0, 0, "R8");
      drv(1, 2'd1, 1, -130, 26'h3000000, 0, 2'd1, 0, "R8");
      drv(1, 2'd1, 0, -200, ONE, 0, 2'd0, 0, "R8");
      // R9 round up into smallest normal
      drv(1, 2'd1, 0, -127, 26'h3FFFFFE, 0, 2'd0, 0, "R9");
      drv(1, 2'd1, 1, -127, 26'h3FFFFF8, 0, 2'd3, 1, "R9");
      // R10 underflow rules
      drv(1, 2'd1, 0, -127, ONE, 0, 2'd0, 1, "R10");
      drv(1, 2'd1, 0, -200, ONE, 0, 2'd2, 0, "R10");
      drv(1, 2'd1, 0, -128, ONE | 26'h1, 0, 2'd1, 0, "R10");
      // R11 overflow in every mode and sign
      for (int md = 0; md < 4; md++)
         for (int sg = 0; sg < 2; sg++)
            drv(1, 2'd1, sg[0], 128, ONE, 0, md[1:0], 0, "R11");
      drv(1, 2'd1, 0, 127, 26'h3FFFFFE, 0, 2'd0, 0, "R11");
      drv(1, 2'd1, 1, 127, 26'h3FFFFFE, 0, 2'd1, 0, "R11");
      drv(1, 2'd1, 1, 300, ONE, 0, 2'd2, 0, "R11");
      idle();
      idle();
      // Random sweep, with occasional idle cycles (R1 streaming)
      for (int k = 0; k < 600; k++) begin
         int e;
         logic [25:0] m;
         e = int'($urandom_range(0, 300)) - 160;
         m = {1'b1, 25'($urandom)};
         if (k % 7 == 3) idle();
         drv(1, ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'd1, 1'($urandom), e, m,
             1'($urandom), 2'($urandom), 1'($urandom), "R5");
      end
      idle();
      idle();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual hung expected completion");
         finish_run();
      end
   end

endmodule